// File: doc/BRIEF.md
# UART Transmitter with Wake-Up Framing

This block serialises one byte at a time onto an asynchronous serial line and supports two ways of marking the start of a message block for receivers that share the line. A frame consists of a low start bit, the data bits (least significant first), an optional address/data flag bit, and one high stop bit. Every bit lasts from one baud tick to the next; the tick enable comes from outside the block. When no frame is being sent, the line stays high.

A wake request pulse sets an internal pending flag. The next byte write uses the flag and clears it. What the flag does depends on the mode the block samples at that write. In idle-line mode, the frame is preceded by exactly eleven high bit periods, which lets receivers recognise it as an address. In address-bit mode, every frame carries an extra bit after the data bits: 1 when the wake flag was used, 0 otherwise. No idle gap is added in this mode.

The controller has seven named states. IDLE accepts a write and goes to ARM. ARM waits for a tick, then goes to GAP when the frame is an idle-line wake frame and to START otherwise. GAP counts eleven ticks and then goes to START. START goes to DATA on a tick. DATA goes to ADDR (address-bit mode) or STOP after the last data bit. ADDR goes to STOP on a tick. STOP goes back to IDLE on a tick.

Top module: `wake_uart_tx`

## Requirements
- R1: While reset is active and right after it, tx_out is 1 and tx_ready is 1.
- R2: A write (wr_en high while tx_ready is 1) makes tx_ready 0 from the next cycle. tx_ready stays 0 until the baud tick that ends the stop bit, and is 1 in the cycle after that tick.
- R3: A write made while tx_ready is 0 is ignored. It does not change the frame in progress, and no further frame follows it.
- R4: The first bit of a frame (gap or start) is driven after the first baud tick that follows the accepting edge. Each bit holds from one tick to the next. The frame is a start bit of 0, DATA_W data bits least significant first, and a stop bit of 1. The line is 1 whenever no frame is in progress.
- R5: In idle-line mode (mode_sel = 0), a write that uses the wake flag sends exactly GAP_BITS (default 11) bit periods of 1 before its start bit.
- R6: In idle-line mode, a write that does not use the wake flag adds no gap: its start bit is the first bit. Back-to-back frames therefore sit fewer than 10 bit periods apart.
- R7: In address-bit mode (mode_sel = 1), every frame has one extra bit between the last data bit and the stop bit. This bit is 1 if the write used the wake flag and 0 if it did not.
- R8: In address-bit mode, no idle bits are added before the start bit, even for an address frame.
- R9: A wake_req pulse sets the flag, including a pulse made during a frame. The next accepted write uses the flag, as does a write in the same cycle as the pulse, and then clears it. The frame after that one is a data frame.
- R10: The mode is sampled at the accepting write. A change of mode_sel during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte to send |
| wake_req | input | 1 | Pulse that sets the wake flag |
| mode_sel | input | 1 | 0 = idle-line mode, 1 = address-bit mode |
| baud_tick | input | 1 | One-cycle bit-period enable |
| tx_out | output | 1 | Serial line, idle high |
| tx_ready | output | 1 | High when a write will be accepted |

## Verification
The reference model advances on the same edges as the design. tx_ready falls one cycle after the accepting edge. The line takes each new bit value in the cycle after a baud tick edge, and tx_ready rises in the cycle after the tick that ends the stop bit. The bench drives its inputs on falling edges and compares both outputs with the model at every falling edge, which is half a cycle after the registers have moved. Frame checks use only the line values seen in the cycle after each tick. From these values the bench measures the gap length, the data bits, the flag bit and the frame length.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_GAP   = 3'd2,
        ST_START = 3'd3,
        ST_DATA  = 3'd4,
        ST_ADDR  = 3'd5,
        ST_STOP  = 3'd6
    } tx_state_e;

    typedef enum logic {
        MODE_IDLE_LINE = 1'b0,
        MODE_ADDR_BIT  = 1'b1
    } wake_mode_e;

endpackage

// File: rtl/wkt_wake_latch.sv
module wkt_wake_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_req,
    input  logic consume,
    output logic wake_now
);

    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (consume) begin
            flag_q <= 1'b0;
        end else if (wake_req) begin
            flag_q <= 1'b1;
        end
    end

    // a pulse in the same cycle as the write applies to that write
    assign wake_now = flag_q | wake_req;

    // R9
    flag_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> !flag_q);

    // R9
    flag_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !consume) |=> flag_q);

endmodule

// File: rtl/wkt_frame_reg.sv
module wkt_frame_reg
    import wkt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] wr_data,
    input  wake_mode_e        mode_in,
    input  logic              wake_in,
    output logic              data_lsb,
    output wake_mode_e        mode_q,
    output logic              wake_q
);

    logic [DATA_W-1:0] shreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            mode_q  <= MODE_IDLE_LINE;
            wake_q  <= 1'b0;
        end else if (load) begin
            shreg_q <= wr_data;
            mode_q  <= mode_in;
            wake_q  <= wake_in;
        end else if (shift_en) begin
            shreg_q <= {1'b0, shreg_q[DATA_W-1:1]};
        end
    end

    assign data_lsb = shreg_q[0];

    // R10
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mode_q));

    // R9
    wake_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(wake_q));

endmodule

// File: rtl/wkt_bit_count.sv
module wkt_bit_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wkt_tx_fsm.sv
module wkt_tx_fsm
    import wkt_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int GAP_BITS = 11,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             baud_tick,
    input  wake_mode_e       mode_q,
    input  logic             wake_q,
    input  logic             data_lsb,
    input  logic [CNT_W-1:0] cnt,
    output logic             accept,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             shift_en,
    output logic             tx_out,
    output logic             tx_ready
);

    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    tx_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_en) state_d = ST_ARM;
            ST_ARM: begin
                if (baud_tick) begin
                    if (mode_q == MODE_IDLE_LINE && wake_q) state_d = ST_GAP;
                    else                                    state_d = ST_START;
                end
            end
            ST_GAP:   if (baud_tick && cnt == GAP_LAST) state_d = ST_START;
            ST_START: if (baud_tick) state_d = ST_DATA;
            ST_DATA: begin
                if (baud_tick && cnt == DATA_LAST) begin
                    state_d = (mode_q == MODE_ADDR_BIT) ? ST_ADDR : ST_STOP;
                end
            end
            ST_ADDR:  if (baud_tick) state_d = ST_STOP;
            ST_STOP:  if (baud_tick) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept   = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        shift_en = 1'b0;
        tx_out   = 1'b1;
        tx_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tx_ready = 1'b1;
                accept   = wr_en;
            end
            ST_ARM: begin
                cnt_clr = baud_tick;
            end
            ST_GAP: begin
                if (baud_tick) begin
                    if (cnt == GAP_LAST) cnt_clr = 1'b1;
                    else                 cnt_inc = 1'b1;
                end
            end
            ST_START: begin
                tx_out  = 1'b0;
                cnt_clr = baud_tick;
            end
            ST_DATA: begin
                tx_out   = data_lsb;
                shift_en = baud_tick;
                cnt_inc  = baud_tick && (cnt != DATA_LAST);
            end
            ST_ADDR: begin
                tx_out = wake_q;
            end
            ST_STOP: begin
                tx_out = 1'b1;
            end
            default: begin
                tx_out = 1'b1;
            end
        endcase
    end

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_ready) |=> !tx_ready);

    // R2
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(baud_tick));

    // R4
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_out);

    // R4
    hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && state_q != ST_IDLE) |=> $stable(state_q));

    // R5
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (cnt <= GAP_LAST));

    // R8
    no_gap_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (mode_q == MODE_IDLE_LINE));

endmodule

// File: rtl/wake_uart_tx.sv
module wake_uart_tx
    import wkt_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int GAP_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wake_req,
    input  logic              mode_sel,
    input  logic              baud_tick,
    output logic              tx_out,
    output logic              tx_ready
);

    localparam int CNT_MAX = (GAP_BITS > DATA_W) ? GAP_BITS : DATA_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             accept;
    logic             wake_now;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             shift_en;
    logic             data_lsb;
    logic             wake_q;
    wake_mode_e       mode_q;
    logic [CNT_W-1:0] cnt;

    wkt_wake_latch u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_req (wake_req),
        .consume  (accept),
        .wake_now (wake_now)
    );

    wkt_frame_reg #(.DATA_W(DATA_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .shift_en (shift_en),
        .wr_data  (wr_data),
        .mode_in  (wake_mode_e'(mode_sel)),
        .wake_in  (wake_now),
        .data_lsb (data_lsb),
        .mode_q   (mode_q),
        .wake_q   (wake_q)
    );

    wkt_bit_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    wkt_tx_fsm #(
        .DATA_W   (DATA_W),
        .GAP_BITS (GAP_BITS),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .baud_tick (baud_tick),
        .mode_q    (mode_q),
        .wake_q    (wake_q),
        .data_lsb  (data_lsb),
        .cnt       (cnt),
        .accept    (accept),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .shift_en  (shift_en),
        .tx_out    (tx_out),
        .tx_ready  (tx_ready)
    );

endmodule

// File: tb/test_wake_uart_tx.sv
`timescale 1ns/1ps
module test_wake_uart_tx;

    localparam int DATA_W   = 8;
    localparam int GAP_BITS = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wake_req = 1'b0;
    logic              mode_sel = 1'b0;
    logic              baud_tick = 1'b0;
    logic              tx_out;
    logic              tx_ready;

    int checks = 0;
    int errors = 0;
    int div = 0;

    always #10 clk = ~clk;

    wake_uart_tx #(.DATA_W(DATA_W), .GAP_BITS(GAP_BITS)) i_wake_uart_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wake_req  (wake_req),
        .mode_sel  (mode_sel),
        .baud_tick (baud_tick),
        .tx_out    (tx_out),
        .tx_ready  (tx_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // baud tick every fourth cycle
    always @(negedge clk) begin
        if (!rst_n) begin
            div = 0;
            baud_tick = 1'b0;
        end else begin
            div = (div == 3) ? 0 : div + 1;
            baud_tick = (div == 3);
        end
    end

    // behavioural reference model
    bit m_busy = 0;
    bit m_line = 1;
    bit m_wake = 0;
    bit m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_line = 1; m_wake = 0; m_q.delete();
        end else if (!m_busy) begin
            if (wr_en) begin
                bit w;
                w = m_wake | wake_req;
                m_wake = 0;
                m_q.delete();
                if (!mode_sel && w) for (int i = 0; i < GAP_BITS; i++) m_q.push_back(1'b1);
                m_q.push_back(1'b0);
                for (int i = 0; i < DATA_W; i++) m_q.push_back(wr_data[i]);
                if (mode_sel) m_q.push_back(w);
                m_q.push_back(1'b1);
                m_busy = 1;
            end else begin
                m_wake = m_wake | wake_req;
            end
        end else begin
            m_wake = m_wake | wake_req;
            if (baud_tick) begin
                if (m_q.size() == 0) begin
                    m_busy = 0; m_line = 1;
                end else begin
                    m_line = m_q.pop_front();
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 line vs model", int'(tx_out), int'(m_line));
            chk("R2 ready vs model", int'(tx_ready), int'(!m_busy));
        end
    end

    bit bench_pend = 0;

    // disturb: 0 none, 1 ignored write, 2 wake pulse mid-frame, 3 mode flip
    task automatic send_frame(input logic [DATA_W-1:0] d, input bit mode,
                              input bit wake_pre, input bit wake_same, input int disturb);
        bit bits[$];
        bit expq[$];
        bit eff;
        bit t;
        int lead;
        if (wake_pre) begin
            wake_req = 1'b1;
            @(negedge clk); wake_req = 1'b0;
            @(negedge clk);
        end
        eff = bench_pend | wake_pre | wake_same;
        bench_pend = 0;
        mode_sel = mode; wr_data = d; wr_en = 1'b1; wake_req = wake_same;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wake_req = 1'b0;
        chk("R2 ready low after write", int'(tx_ready), 0);
        forever begin
            @(posedge clk); t = baud_tick;
            @(negedge clk);
            wr_en = 1'b0; wake_req = 1'b0;
            if (tx_ready) break;
            if (t) begin
                bits.push_back(tx_out);
                if (bits.size() == 4) begin
                    if (disturb == 1) begin wr_en = 1'b1; wr_data = ~d; end
                    if (disturb == 2) begin wake_req = 1'b1; bench_pend = 1; end
                    if (disturb == 3) mode_sel = ~mode;
                end
            end
        end
        mode_sel = mode;
        if (!mode && eff) for (int i = 0; i < GAP_BITS; i++) expq.push_back(1'b1);
        expq.push_back(1'b0);
        for (int i = 0; i < DATA_W; i++) expq.push_back(d[i]);
        if (mode) expq.push_back(eff);
        expq.push_back(1'b1);
        lead = 0;
        while (lead < bits.size() && bits[lead]) lead++;
        if (!mode) chk(eff ? "R5 gap length" : "R6 no gap", lead, eff ? GAP_BITS : 0);
        else       chk("R8 no gap in address-bit mode", lead, 0);
        chk(mode ? "R7 frame length" : "R4 frame length", bits.size(), expq.size());
        for (int i = 0; i < expq.size() && i < bits.size(); i++)
            chk(mode ? "R7 frame bit" : "R4 frame bit", int'(bits[i]), int'(expq[i]));
        if (mode) chk("R7 flag bit R9", int'(bits[bits.size()-2]), int'(eff));
        if (disturb == 1) begin
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                chk("R3 no frame after ignored write", int'(tx_ready), 1);
            end
        end
        if (disturb == 3) chk("R10 mode held", int'(bits.size()), int'(expq.size()));
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 line in reset", int'(tx_out), 1);
        chk("R1 ready in reset", int'(tx_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 line after reset", int'(tx_out), 1);
        chk("R1 ready after reset", int'(tx_ready), 1);

        send_frame(8'hA5, 1'b0, 1'b0, 1'b0, 0);   // R4 R6
        send_frame(8'h3C, 1'b0, 1'b1, 1'b0, 0);   // R5
        send_frame(8'hC3, 1'b0, 1'b0, 1'b0, 0);   // R9 consumed
        send_frame(8'h81, 1'b1, 1'b0, 1'b1, 0);   // R7 R8 same-cycle wake
        send_frame(8'h7E, 1'b1, 1'b0, 1'b0, 0);   // R7 data flag
        send_frame(8'h5A, 1'b1, 1'b0, 1'b0, 1);   // R3
        send_frame(8'h11, 1'b0, 1'b0, 1'b0, 2);   // R9 wake during frame
        send_frame(8'h22, 1'b0, 1'b0, 1'b0, 0);   // R9 pending applies here
        send_frame(8'hF0, 1'b1, 1'b1, 1'b0, 3);   // R10 mode flip
        send_frame(8'h0F, 1'b0, 1'b1, 1'b0, 3);   // R10 mode flip, R5
        send_frame(8'hFF, 1'b0, 1'b0, 1'b0, 0);   // R6 back to back
        repeat (8) @(negedge clk);
        report();
    end

endmodule